// File: doc/BRIEF.md
# Dual-Lane Serial Flash Read Engine

This block sits on the host side of a serial NOR memory and turns read requests into byte streams. Each request carries a start address, a byte count (given as count minus one), a dummy-cycle count and an optional exit flag. The engine generates the serial clock and the active-low select and shifts the outgoing fields. It then collects two bits per serial clock from the two data lanes and hands out assembled bytes on a valid/ready port. When the consumer stalls, the engine holds the serial clock low before the sampling edge that would complete the next byte, so no byte is lost.

Every frame sends an 8-bit mode byte after the address. The engine predicts whether the next request will follow on from the current one. If it will, it sends 0xA0 and the memory stays in continuous read. The next frame then starts with the address and has no instruction byte. In all other cases it sends 0x00, and the frame after that carries the instruction again. During the mode field the host stops driving the lanes two cycles early, so the memory can take over the bus without contention.

Top module: `dual_read_engine`

## Requirements
- R1: During and right after reset the select is high, the serial clock is low, both lane output enables are low, the request port is ready and no output byte is valid.
- R2: A frame that is not continuous sends the instruction CMD_CODE (default 0xBB) first. It uses eight serial clocks, one bit per clock on lane 0, MSB first, with lane 1 not driven.
- R3: The address follows, ADDR_W bits, two bits per clock, MSB first, with lane 1 carrying the higher bit of each pair. Four mode clocks follow the address. The mode byte is 0xA0 when the exit flag is low and either no request has been taken since reset or the request address equals the previous start address plus the previous byte count (modulo 2^ADDR_W). Otherwise the mode byte is 0x00.
- R4: A frame that follows a frame whose mode byte was 0xA0 leaves out the instruction and starts directly with the address.
- R5: The host drives both lanes during the address and the first two mode clocks. It drives neither lane during the last two mode clocks, the dummy clocks, the data clocks, or while deselected. Lane 1 is never driven without lane 0.
- R6: The number of dummy clocks between the mode field and the data equals the dummy-cycle input (0 to 15) as sampled when the request is accepted. Later changes to that input have no effect on the frame.
- R7: The frame returns reqCntM1+1 bytes from consecutive addresses, starting at the request address and wrapping at 2^ADDR_W. Bits are sampled on serial clock rising edges, two per clock, lane 1 high, MSB first.
- R8: The select stays low from the first instruction or address clock through the last data clock. The serial clock is low whenever the select is high.
- R9: While a valid output byte is not accepted, it stays valid and unchanged.
- R10: The serial clock high phase lasts DIV_HALF system clocks.
- R11: The request port is ready only while the select is high. Between frames the select stays high for at least 2*DIV_HALF system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Read request offered |
| reqReady | output | 1 | Engine idle and able to take a request |
| reqAddr | input | ADDR_W | Start byte address |
| reqCntM1 | input | CNT_W | Number of bytes minus one |
| reqExit | input | 1 | Force mode byte 0x00 for this frame |
| dummyCycles | input | 4 | Dummy clocks for this frame |
| sck | output | 1 | Serial clock |
| csN | output | 1 | Active-low chip select |
| io0Out | output | 1 | Lane 0 output value |
| io0Oe | output | 1 | Lane 0 output enable |
| io0In | input | 1 | Lane 0 input value |
| io1Out | output | 1 | Lane 1 output value |
| io1Oe | output | 1 | Lane 1 output enable |
| io1In | input | 1 | Lane 1 input value |
| dataValid | output | 1 | Output byte valid |
| dataReady | input | 1 | Consumer accepts the byte |
| dataByte | output | 8 | Assembled read byte |

## Verification
The bench builds the engine with ADDR_W=16, CNT_W=6 and DIV_HALF=2. The narrow address puts the wrap from 0xFFFF to 0x0000 within reach, both in the returned data and in the check for a continuing address. The small count field keeps frames short, so many continuous and non-continuous transitions fit in one run. DIV_HALF=2 makes the held-low stall phase distinct from the high phase, so backpressure and clock-shape checks can be told apart.

// File: rtl/dre_pkg.sv
package dre_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INSTR,
    ST_ADDR,
    ST_MODE,
    ST_DUMMY,
    ST_DATA,
    ST_TAIL
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadFrame;   // request accepted, load shifters
    logic modeCont;    // mode byte keeps continuous read
    logic shiftInstr;  // advance instruction shifter one bit
    logic shiftPair;   // advance address/mode shifter two bits
    logic sampleIn;    // capture a lane pair
    logic pushByte;    // this pair completes a byte
    logic singleLane;  // instruction phase, lane 0 only
  } dpCtl_t;

  localparam logic [7:0] MODE_CONT = 8'hA0;
  localparam logic [7:0] MODE_EXIT = 8'h00;

endpackage

// File: rtl/dre_sckgen.sv
module dre_sckgen #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  input  logic holdRise,
  output logic sck,
  output logic riseEv,
  output logic fallEv
);
  localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [DIV_W-1:0] divCnt;
  logic sckQ;
  logic atEnd;

  assign atEnd  = (divCnt == DIV_W'(DIV_HALF - 1));
  assign riseEv = run && atEnd && !sckQ && !holdRise;
  assign fallEv = run && atEnd && sckQ;
  assign sck    = sckQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      sckQ   <= 1'b0;
    end else if (!run) begin
      divCnt <= '0;
      sckQ   <= 1'b0;
    end else if (atEnd) begin
      if (riseEv || fallEv) begin
        sckQ   <= ~sckQ;
        divCnt <= '0;
      end
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end
endmodule

// File: rtl/dre_ctrl.sv
module dre_ctrl
  import dre_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int CNT_W    = 8,
  parameter int DIV_HALF = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [CNT_W-1:0] reqCntM1,
  input  logic             reqExit,
  input  logic [3:0]       dummyCycles,
  input  logic             addrContig,
  input  logic             dataValid,
  input  logic             dataReady,
  input  logic             riseEv,
  input  logic             fallEv,
  output logic             run,
  output logic             holdRise,
  output logic             csN,
  output logic             io0Oe,
  output logic             io1Oe,
  output dpCtl_t           ctl
);
  localparam int ADDR_SLOTS = ADDR_W / 2;
  localparam int SLOT_W     = $clog2(ADDR_SLOTS + 16);
  localparam int TAIL_CYC   = 2 * DIV_HALF;
  localparam int TAIL_W     = $clog2(TAIL_CYC + 1);

  phase_e            state;
  logic [SLOT_W-1:0] slotCnt;
  logic [3:0]        dummyQ;
  logic [CNT_W-1:0]  bytesLeft;
  logic [1:0]        pairCnt;
  logic [TAIL_W-1:0] tailCnt;
  logic              lastDone;
  logic              contMode;
  logic              prevValid;
  logic              csNQ;

  logic accept;
  logic modeCont;
  logic earlyMode;

  assign accept    = (state == ST_IDLE) && reqValid;
  assign modeCont  = !reqExit && (!prevValid || addrContig);
  assign reqReady  = (state == ST_IDLE);
  assign csN       = csNQ;
  assign run       = (state == ST_INSTR) || (state == ST_ADDR) || (state == ST_MODE) ||
                     (state == ST_DUMMY) || (state == ST_DATA);
  assign holdRise  = (state == ST_DATA) && (pairCnt == 2'd3) && dataValid && !dataReady;
  assign earlyMode = (state == ST_MODE) && (slotCnt < SLOT_W'(2));
  assign io0Oe     = (state == ST_INSTR) || (state == ST_ADDR) || earlyMode;
  assign io1Oe     = (state == ST_ADDR) || earlyMode;

  always_comb begin
    ctl            = '0;
    ctl.loadFrame  = accept;
    ctl.modeCont   = modeCont;
    ctl.singleLane = (state == ST_INSTR);
    ctl.shiftInstr = fallEv && (state == ST_INSTR);
    ctl.shiftPair  = fallEv && ((state == ST_ADDR) || (state == ST_MODE));
    ctl.sampleIn   = riseEv && (state == ST_DATA);
    ctl.pushByte   = riseEv && (state == ST_DATA) && (pairCnt == 2'd3);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      slotCnt   <= '0;
      dummyQ    <= '0;
      bytesLeft <= '0;
      pairCnt   <= '0;
      tailCnt   <= '0;
      lastDone  <= 1'b0;
      contMode  <= 1'b0;
      prevValid <= 1'b0;
      csNQ      <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          csNQ      <= 1'b0;
          dummyQ    <= dummyCycles;
          bytesLeft <= reqCntM1;
          slotCnt   <= '0;
          pairCnt   <= '0;
          lastDone  <= 1'b0;
          contMode  <= modeCont;
          prevValid <= 1'b1;
          state     <= contMode ? ST_ADDR : ST_INSTR;
        end
        ST_INSTR: if (fallEv) begin
          if (slotCnt == SLOT_W'(7)) begin
            slotCnt <= '0;
            state   <= ST_ADDR;
          end else slotCnt <= slotCnt + 1'b1;
        end
        ST_ADDR: if (fallEv) begin
          if (slotCnt == SLOT_W'(ADDR_SLOTS - 1)) begin
            slotCnt <= '0;
            state   <= ST_MODE;
          end else slotCnt <= slotCnt + 1'b1;
        end
        ST_MODE: if (fallEv) begin
          if (slotCnt == SLOT_W'(3)) begin
            slotCnt <= '0;
            state   <= (dummyQ == 4'd0) ? ST_DATA : ST_DUMMY;
          end else slotCnt <= slotCnt + 1'b1;
        end
        ST_DUMMY: if (fallEv) begin
          if (slotCnt + 1'b1 == SLOT_W'(dummyQ)) begin
            slotCnt <= '0;
            state   <= ST_DATA;
          end else slotCnt <= slotCnt + 1'b1;
        end
        ST_DATA: begin
          if (ctl.sampleIn) begin
            pairCnt <= pairCnt + 1'b1;
            if (pairCnt == 2'd3) begin
              if (bytesLeft == '0) lastDone <= 1'b1;
              else bytesLeft <= bytesLeft - 1'b1;
            end
          end
          if (fallEv && lastDone) begin
            state   <= ST_TAIL;
            csNQ    <= 1'b1;
            tailCnt <= '0;
          end
        end
        ST_TAIL: begin
          if (tailCnt == TAIL_W'(TAIL_CYC - 1)) state <= ST_IDLE;
          else tailCnt <= tailCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dre_datapath.sv
module dre_datapath
  import dre_pkg::*;
#(
  parameter int         ADDR_W   = 24,
  parameter int         CNT_W    = 8,
  parameter logic [7:0] CMD_CODE = 8'hBB
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CNT_W-1:0]  reqCntM1,
  input  logic              io0In,
  input  logic              io1In,
  input  logic              dataReady,
  output logic              addrContig,
  output logic              io0Out,
  output logic              io1Out,
  output logic              dataValid,
  output logic [7:0]        dataByte
);
  localparam int FR_W = ADDR_W + 8;

  logic [7:0]        instrSh;
  logic [FR_W-1:0]   frameSh;
  logic [ADDR_W-1:0] nextAddr;
  logic [5:0]        rxSh;

  assign addrContig = (reqAddr == nextAddr);
  assign io0Out     = ctl.singleLane ? instrSh[7] : frameSh[FR_W-2];
  assign io1Out     = ctl.singleLane ? 1'b0 : frameSh[FR_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      instrSh   <= '0;
      frameSh   <= '0;
      nextAddr  <= '0;
      rxSh      <= '0;
      dataValid <= 1'b0;
      dataByte  <= '0;
    end else begin
      if (ctl.loadFrame) begin
        instrSh  <= CMD_CODE;
        frameSh  <= {reqAddr, (ctl.modeCont ? MODE_CONT : MODE_EXIT)};
        nextAddr <= reqAddr + ADDR_W'(reqCntM1) + ADDR_W'(1);
      end else begin
        if (ctl.shiftInstr) instrSh <= {instrSh[6:0], 1'b0};
        if (ctl.shiftPair)  frameSh <= {frameSh[FR_W-3:0], 2'b00};
      end
      if (ctl.sampleIn) rxSh <= {rxSh[3:0], io1In, io0In};
      if (ctl.pushByte) begin
        dataByte  <= {rxSh, io1In, io0In};
        dataValid <= 1'b1;
      end else if (dataReady) begin
        dataValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dual_read_engine.sv
module dual_read_engine
  import dre_pkg::*;
#(
  parameter int         ADDR_W   = 24,
  parameter int         CNT_W    = 8,
  parameter int         DIV_HALF = 2,
  parameter logic [7:0] CMD_CODE = 8'hBB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CNT_W-1:0]  reqCntM1,
  input  logic              reqExit,
  input  logic [3:0]        dummyCycles,
  output logic              sck,
  output logic              csN,
  output logic              io0Out,
  output logic              io0Oe,
  input  logic              io0In,
  output logic              io1Out,
  output logic              io1Oe,
  input  logic              io1In,
  output logic              dataValid,
  input  logic              dataReady,
  output logic [7:0]        dataByte
);
  dpCtl_t ctl;
  logic   run;
  logic   holdRise;
  logic   riseEv;
  logic   fallEv;
  logic   addrContig;

  dre_sckgen #(.DIV_HALF(DIV_HALF)) u_sckgen (
    .clk(clk), .rstN(rstN), .run(run), .holdRise(holdRise),
    .sck(sck), .riseEv(riseEv), .fallEv(fallEv)
  );

  dre_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DIV_HALF(DIV_HALF)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqCntM1(reqCntM1), .reqExit(reqExit), .dummyCycles(dummyCycles),
    .addrContig(addrContig), .dataValid(dataValid), .dataReady(dataReady),
    .riseEv(riseEv), .fallEv(fallEv), .run(run), .holdRise(holdRise),
    .csN(csN), .io0Oe(io0Oe), .io1Oe(io1Oe), .ctl(ctl)
  );

  dre_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CMD_CODE(CMD_CODE)) u_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqCntM1(reqCntM1),
    .io0In(io0In), .io1In(io1In), .dataReady(dataReady), .addrContig(addrContig),
    .io0Out(io0Out), .io1Out(io1Out), .dataValid(dataValid), .dataByte(dataByte)
  );
endmodule

// File: rtl/dre_checker.sv
module dre_checker (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       sck,
  input logic       io0Oe,
  input logic       io1Oe,
  input logic       reqReady,
  input logic       dataValid,
  input logic       dataReady,
  input logic [7:0] dataByte
);
  a_r8_sck_low_deselected: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);

  a_r5_released_deselected: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (!io0Oe && !io1Oe));

  a_r5_lane1_needs_lane0: assert property (@(posedge clk) disable iff (!rstN)
    io1Oe |-> io0Oe);

  a_r9_hold_byte: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && !dataReady) |=> (dataValid && $stable(dataByte)));

  a_r11_ready_deselected: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> csN);
endmodule

bind dual_read_engine dre_checker u_dre_checker (
  .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .io0Oe(io0Oe), .io1Oe(io1Oe),
  .reqReady(reqReady), .dataValid(dataValid), .dataReady(dataReady), .dataByte(dataByte)
);

// File: tb/dual_read_engine_bench.sv
module dual_read_engine_bench;
  localparam int         AW  = 16;
  localparam int         CW  = 6;
  localparam int         DH  = 2;
  localparam logic [7:0] CMD = 8'hBB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqReady, reqExit = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [CW-1:0] reqCntM1 = '0;
  logic [3:0] dummyCycles = '0;
  logic sck, csN, io0Out, io0Oe, io1Out, io1Oe;
  logic io0In = 1'b0, io1In = 1'b0;
  logic dataValid, dataReady = 1'b0;
  logic [7:0] dataByte;

  always #4 clk = ~clk;

  dual_read_engine #(.ADDR_W(AW), .CNT_W(CW), .DIV_HALF(DH), .CMD_CODE(CMD)) u_dual_read_engine (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqCntM1(reqCntM1), .reqExit(reqExit), .dummyCycles(dummyCycles), .sck(sck), .csN(csN),
    .io0Out(io0Out), .io0Oe(io0Oe), .io0In(io0In), .io1Out(io1Out), .io1Oe(io1Oe),
    .io1In(io1In), .dataValid(dataValid), .dataReady(dataReady), .dataByte(dataByte)
  );

  int total = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] memByte(input logic [AW-1:0] a);
    return 8'(a[7:0] * 8'd29) ^ 8'(a >> 8) ^ 8'h5A;
  endfunction

  // expectations set by the request task
  bit benchCont = 0, havePrev = 0, expInstr = 0;
  logic [AW-1:0] expNext = '0, expAddr = '0, expByteAddr = '0;
  logic [7:0] expMode = '0;
  int curDummy = 0, expBytesLeft = 0, expBytesTotal = 0, framesDone = 0, readyPct = 100;

  // memory model state
  bit prevSck = 0, prevCs = 1, memCont = 0, hasInstr = 0, oeBad = 0, highBad = 0, gapBad = 0;
  int riseCnt = 0, pairIdx = 0, highLen = 0, gapLen = 0;
  logic [7:0] rxInstr = '0, rxMode = '0;
  logic [AW-1:0] rxAddr = '0, dataAddr = '0;

  always @(negedge clk) begin
    int nI, pre, k;
    logic [7:0] sh;
    nI  = hasInstr ? 8 : 0;
    pre = nI + AW / 2 + 4 + curDummy;
    if (prevCs && !csN) begin
      if (framesDone > 0 && gapLen < 2 * DH) gapBad = 1;
      hasInstr = !memCont; riseCnt = 0; pairIdx = 0; oeBad = 0;
      rxInstr = '0; rxAddr = '0; rxMode = '0;
      nI  = hasInstr ? 8 : 0;
      pre = nI + AW / 2 + 4 + curDummy;
    end
    if (!prevCs && csN) begin
      chk(hasInstr == expInstr, "R4", "instruction present", hasInstr, expInstr);
      if (hasInstr) chk(rxInstr == CMD, "R2", "instruction byte", rxInstr, CMD);
      chk(rxAddr == expAddr, "R3", "address", rxAddr, expAddr);
      chk(rxMode == expMode, "R3", "mode byte", rxMode, expMode);
      chk(!oeBad, "R5", "lane release", oeBad, 0);
      chk(riseCnt == pre + 4 * expBytesTotal, "R6", "clocks in frame (R8)",
          riseCnt, pre + 4 * expBytesTotal);
      memCont = (rxMode[7:4] == 4'hA);
      framesDone++;
      gapLen = 0;
    end
    if (csN) gapLen++;
    if (!prevSck && sck && !csN) begin
      if (riseCnt < nI) begin
        rxInstr = {rxInstr[6:0], io0Out};
        if (!io0Oe || io1Oe) oeBad = 1;
      end else if (riseCnt < nI + AW / 2) begin
        rxAddr = {rxAddr[AW-3:0], io1Out, io0Out};
        if (!io0Oe || !io1Oe) oeBad = 1;
      end else if (riseCnt < nI + AW / 2 + 4) begin
        rxMode = {rxMode[5:0], io1Out, io0Out};
        k = riseCnt - nI - AW / 2;
        if (k < 2 && (!io0Oe || !io1Oe)) oeBad = 1;
        if (k >= 2 && (io0Oe || io1Oe)) oeBad = 1;
      end else if (io0Oe || io1Oe) oeBad = 1;
      riseCnt++;
    end
    if (prevSck && !sck) begin
      if (highLen != DH) highBad = 1;
      highLen = 0;
      if (!csN && riseCnt >= pre) begin
        if (riseCnt == pre) begin dataAddr = rxAddr; pairIdx = 0; end
        sh = memByte(dataAddr) << (2 * pairIdx);
        io1In = sh[7]; io0In = sh[6];
        pairIdx++;
        if (pairIdx == 4) begin pairIdx = 0; dataAddr++; end
      end
    end
    if (sck) highLen++;
    prevSck = sck; prevCs = csN;
  end

  // consumer with random backpressure
  bit stallWatch = 0, stallBad = 0;
  logic [7:0] heldByte = '0;
  always @(negedge clk) if (rstN) begin
    if (stallWatch && (!dataValid || dataByte != heldByte)) stallBad = 1;
    dataReady = (($urandom % 100) < readyPct);
    if (dataValid && dataReady) begin
      chk(expBytesLeft > 0, "R7", "byte count", expBytesLeft, 1);
      chk(dataByte == memByte(expByteAddr), "R7", "data byte", dataByte, memByte(expByteAddr));
      expBytesLeft--; expByteAddr++; stallWatch = 0;
    end else if (dataValid) begin
      stallWatch = 1; heldByte = dataByte;
    end else stallWatch = 0;
  end

  task automatic doReq(input logic [AW-1:0] a, input int cnt, input bit ex, input int dmy);
    int target;
    expInstr = !benchCont;
    expMode = (ex || (havePrev && a != expNext)) ? 8'h00 : 8'hA0;
    benchCont = (expMode == 8'hA0);
    havePrev = 1;
    expNext = a + AW'(cnt) + AW'(1);
    expAddr = a; curDummy = dmy; expByteAddr = a;
    expBytesLeft = cnt + 1; expBytesTotal = cnt + 1;
    target = framesDone + 1;
    while (!reqReady) @(negedge clk);
    reqAddr = a; reqCntM1 = CW'(cnt); reqExit = ex; dummyCycles = 4'(dmy); reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    reqExit = 1'($urandom);
    dummyCycles = 4'($urandom);   // R6: must not affect the running frame
    chk(reqReady == 1'b0, "R11", "busy after accept", reqReady, 0);
    while (framesDone < target || expBytesLeft != 0) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", framesDone, -1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    chk(csN && !sck && !io0Oe && !io1Oe && reqReady && !dataValid, "R1", "in reset",
        {csN, sck, io0Oe, io1Oe, reqReady, dataValid}, 6'b100010);
    rstN = 1'b1;
    @(negedge clk);
    chk(csN == 1'b1, "R1", "select after reset", csN, 1);
    chk(reqReady && !dataValid, "R1", "ready/valid after reset", {reqReady, dataValid}, 2'b10);

    readyPct = 100;
    doReq(16'h1234, 3, 0, 8);    // first frame: instruction, mode A0
    doReq(16'h1238, 0, 0, 0);    // continuous, zero dummy
    doReq(16'h0100, 2, 0, 15);   // jump: no instruction, mode 00
    doReq(16'h0103, 5, 0, 1);    // instruction again
    readyPct = 30;
    doReq(16'h0109, 7, 1, 4);    // exit flag forces 00
    doReq(16'hFFFE, 3, 0, 2);    // data wraps past top
    doReq(16'h0002, 1, 0, 3);    // continues across wrap
    doReq(16'h0004, 0, 0, 0);
    readyPct = 60;
    for (int i = 0; i < 24; i++) begin
      logic [AW-1:0] a;
      a = ($urandom % 2) ? expNext : AW'($urandom);
      doReq(a, $urandom % 16, (($urandom % 10) == 0), $urandom % 16);
    end

    chk(!highBad, "R10", "sck high phase", highBad, 0);
    chk(!gapBad, "R11", "deselect gap", gapBad, 0);
    chk(!stallBad, "R9", "held byte stable", stallBad, 0);
    chk(expBytesLeft == 0, "R7", "bytes outstanding", expBytesLeft, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule